// File: doc/BRIEF.md
# ATA Task-File Register and Status Controller

This block is the device-side register file of a parallel ATA target. A host-side bus adapter presents a 3-bit register offset with a read or a write strobe. The block holds the sector-count, three LBA bytes, the device/head register, a write-only feature byte and an error byte. It decodes command bytes and drives the status byte through its idle, busy and data-request phases. An interrupt request line tells the host that a command has finished or that data is ready.

Two commands are executed. The identify command (0xEC) opens a PIO data-in phase that hands out a fixed table of 16-bit words, one per read of the data register. The flush command (0xE7) holds the device busy for a programmable number of clock cycles and then returns it to ready. Any other opcode is rejected at once and reported through the error register. Media access, DMA and the host bus are handled outside the block.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status byte (offset 7) reads 0x40, the error byte (offset 1) reads 0x00, sector count, LBA bytes and device register read 0x00, and `irq` is low.
- R2: Offsets 2, 3, 4, 5 and 6 read back, zero-extended, the byte last written to them. A write to offset 1 goes to the feature byte and never changes what a read of offset 1 returns, which is the error byte.
- R3: Writing 0xEC to offset 7 while the device is idle and selected puts status at 0x48 (DRDY and DRQ) on the next cycle and raises `irq`. The k-th read of offset 0 that follows (k = 0..ID_WORDS-1) returns ((k*257) mod 65536) XOR ID_SEED, and status stays 0x48 until the last word has been read.
- R4: In the cycle after the last identify word is read, status is 0x40. Reads of offset 0 outside a data phase return 0x0000 and change nothing.
- R5: Writing 0xE7 while the device is idle and selected makes status read 0xC0 (BSY and DRDY) for exactly FLUSH_CYCLES cycles after the write edge. After that it reads 0x40 and `irq` is high.
- R6: Writing any opcode other than 0xEC or 0xE7 while the device is idle and selected never sets BSY. On the next cycle status reads 0x41 (DRDY and ERR), error reads 0x04 (abort, bit 2), and `irq` is high.
- R7: An accepted identify or flush command clears ERR in status and the abort bit in the error byte.
- R8: A read of offset 7 while the device is selected drops `irq` on the next cycle. A completion event in the same cycle wins over the clear.
- R9: While device register bit 4 is 1 the device is deselected. Reads of offsets 0, 1 and 7 return 0x0000, and command writes have no effect on status or error.
- R10: A command write while status shows BSY or DRQ is ignored. The phase in progress runs to completion unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset (0 data, 1 feature/error, 2 sector count, 3-5 LBA bytes, 6 device, 7 command/status) |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; its side effects (word advance, irq clear) take effect at the clock edge |
| wdata | input | 8 | Write data byte |
| rdata | output | 16 | Combinational read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples `rdata` 1 ns after it drives an offset at the falling edge. Any side effect of a strobe shows up at the next falling edge, after the one rising edge in between. A command write shows its status in the first sample after its edge. The flush window is sampled once per cycle, FLUSH_CYCLES times at 0xC0 and then once at 0x40, so a window that is one cycle short or long is caught. Identify words are checked on the same sample as their read strobe, and the counter advance is seen in the following read.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_BUSY = 2'd1,
        M_DRQ  = 2'd2
    } mode_e;

    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_DRDY = 8'h40;
    localparam logic [7:0] ST_DRQ  = 8'h08;
    localparam logic [7:0] ST_ERR  = 8'h01;
    localparam logic [7:0] ER_ABRT = 8'h04;

    localparam logic [7:0] OP_IDENT = 8'hEC;
    localparam logic [7:0] OP_FLUSH = 8'hE7;

    localparam int DEV_SEL_BIT = 4;

    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_FEAT  = 3'd1;
    localparam logic [2:0] A_NSECT = 3'd2;
    localparam logic [2:0] A_LBAL  = 3'd3;
    localparam logic [2:0] A_LBAM  = 3'd4;
    localparam logic [2:0] A_LBAH  = 3'd5;
    localparam logic [2:0] A_DEV   = 3'd6;
    localparam logic [2:0] A_CMD   = 3'd7;

endpackage

// File: rtl/ata_id_rom.sv
module ata_id_rom #(
    parameter int          WORDS = 256,
    parameter logic [15:0] SEED  = 16'h5AA5
) (
    input  logic [$clog2(WORDS)-1:0] idx,
    output logic [15:0]              word
);
    logic [15:0] tbl [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [15:0] BASE = 16'((g * 257) % 65536);
        assign tbl[g] = BASE ^ SEED;
    end

    assign word = tbl[idx];
endmodule

// File: rtl/ata_busy_timer.sv
module ata_busy_timer #(
    parameter int CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int          ID_WORDS     = 256,
    parameter int          FLUSH_CYCLES = 24,
    parameter logic [15:0] ID_SEED      = 16'h5AA5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [15:0] rdata,
    output logic        irq
);
    localparam int IDX_W = $clog2(ID_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

    typedef struct packed {
        mode_e            mode;
        logic             err;
        logic [7:0]       feat;
        logic [7:0]       nsect;
        logic [7:0]       lbal;
        logic [7:0]       lbam;
        logic [7:0]       lbah;
        logic [7:0]       dev;
        logic [IDX_W-1:0] idx;
        logic             irq;
    } tf_t;

    tf_t         tf_d, tf_q;
    logic [15:0] id_word;
    logic        flush_start, flush_done;
    logic        sel;
    logic [7:0]  status_b, error_b;

    ata_id_rom #(.WORDS(ID_WORDS), .SEED(ID_SEED)) u_rom (
        .idx  (tf_q.idx),
        .word (id_word)
    );

    ata_busy_timer #(.CYCLES(FLUSH_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (flush_start),
        .done  (flush_done)
    );

    assign sel = ~tf_q.dev[DEV_SEL_BIT];

    always_comb begin
        status_b = ST_DRDY;
        if (tf_q.mode == M_BUSY) status_b = status_b | ST_BSY;
        if (tf_q.mode == M_DRQ)  status_b = status_b | ST_DRQ;
        if (tf_q.err)            status_b = status_b | ST_ERR;
        error_b = tf_q.err ? ER_ABRT : 8'h00;
    end

    always_comb begin
        rdata = 16'h0000;
        case (addr)
            A_DATA:  if (sel && tf_q.mode == M_DRQ) rdata = id_word;
            A_FEAT:  if (sel) rdata = {8'h00, error_b};
            A_NSECT: rdata = {8'h00, tf_q.nsect};
            A_LBAL:  rdata = {8'h00, tf_q.lbal};
            A_LBAM:  rdata = {8'h00, tf_q.lbam};
            A_LBAH:  rdata = {8'h00, tf_q.lbah};
            A_DEV:   rdata = {8'h00, tf_q.dev};
            default: if (sel) rdata = {8'h00, status_b};
        endcase
    end

    always_comb begin
        tf_d        = tf_q;
        flush_start = 1'b0;

        if (wr_en) begin
            case (addr)
                A_FEAT:  tf_d.feat  = wdata;
                A_NSECT: tf_d.nsect = wdata;
                A_LBAL:  tf_d.lbal  = wdata;
                A_LBAM:  tf_d.lbam  = wdata;
                A_LBAH:  tf_d.lbah  = wdata;
                A_DEV:   tf_d.dev   = wdata;
                default: ;
            endcase
        end

        // status read acknowledges the interrupt; later set events override
        if (rd_en && addr == A_CMD && sel) tf_d.irq = 1'b0;

        if (wr_en && addr == A_CMD && sel && tf_q.mode == M_IDLE) begin
            case (wdata)
                OP_IDENT: begin
                    tf_d.mode = M_DRQ;
                    tf_d.idx  = '0;
                    tf_d.err  = 1'b0;
                    tf_d.irq  = 1'b1;
                end
                OP_FLUSH: begin
                    tf_d.mode   = M_BUSY;
                    tf_d.err    = 1'b0;
                    flush_start = 1'b1;
                end
                default: begin
                    tf_d.err = 1'b1;
                    tf_d.irq = 1'b1;
                end
            endcase
        end

        if (rd_en && addr == A_DATA && sel && tf_q.mode == M_DRQ) begin
            if (tf_q.idx == LAST_IDX) begin
                tf_d.mode = M_IDLE;
                tf_d.idx  = '0;
            end else begin
                tf_d.idx = tf_q.idx + 1'b1;
            end
        end

        if (tf_q.mode == M_BUSY && flush_done) begin
            tf_d.mode = M_IDLE;
            tf_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tf_q <= '{mode: M_IDLE, default: '0};
        else        tf_q <= tf_d;
    end

    assign irq = tf_q.irq;
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic       irq,
    input logic [7:0] status_b,
    input logic [7:0] error_b,
    input logic       sel
);
    logic idle;
    assign idle = !status_b[7] && !status_b[3];

    a_r3_drq_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        status_b[3] |-> status_b == 8'h48);

    a_r3_ident_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd7 && sel && idle && wdata == 8'hEC)
        |=> (status_b == 8'h48 && irq));

    a_r5_busy_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        status_b[7] |-> status_b == 8'hC0);

    a_r5_flush_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_b[7]) |-> (status_b == 8'h40 && irq));

    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd7 && sel && idle && wdata != 8'hEC && wdata != 8'hE7)
        |=> (status_b == 8'h41 && error_b == 8'h04 && irq));

    a_r6_err_abrt: assert property (@(posedge clk) disable iff (!rst_n)
        status_b[0] |-> error_b == 8'h04);

    a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd7 && sel && !status_b[7]) |=> !irq);

    a_r9_unsel_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd7 && !sel && !status_b[7]) |=> $stable(status_b));
endmodule

bind ata_taskfile_ctrl ata_taskfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .irq      (irq),
    .status_b (status_b),
    .error_b  (error_b),
    .sel      (sel)
);

// File: tb/ata_taskfile_ctrl_tb.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl_tb_top;
    localparam int NW   = 256;
    localparam int NFL  = 6;
    localparam logic [15:0] SEED = 16'h5AA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    ata_taskfile_ctrl #(.ID_WORDS(NW), .FLUSH_CYCLES(NFL), .ID_SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [15:0] id_exp(input int k);
        return 16'((k * 257) % 65536) ^ SEED;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        addr = a; rd_en = 1'b0;
        #1 v = rdata;
    endtask

    task automatic report;
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd7, v); check("R1 status", v, 16'h0040);
        peek(3'd1, v); check("R1 error", v, 16'h0000);
        peek(3'd2, v); check("R1 nsect", v, 16'h0000);
        peek(3'd6, v); check("R1 device", v, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);

        // R2 register readback sweep
        for (int a = 2; a <= 5; a++) begin
            for (int x = 0; x < 256; x += 15) begin
                bus_wr(3'(a), 8'(x));
                peek(3'(a), v); check("R2 readback", v, 16'(x));
            end
        end
        for (int x = 0; x < 256; x += 32) begin
            bus_wr(3'd6, 8'(x) & 8'hEF);
            peek(3'd6, v); check("R2 device readback", v, 16'(8'(x) & 8'hEF));
        end
        bus_wr(3'd6, 8'h40);
        bus_wr(3'd1, 8'hFF);
        peek(3'd1, v); check("R2 feature not in error", v, 16'h0000);

        // R3 / R4 identify data phase
        bus_wr(3'd7, 8'hEC);
        peek(3'd7, v); check("R3 status after identify", v, 16'h0048);
        check("R3 irq", {15'b0, irq}, 16'h0001);
        bus_rd(3'd7, v);
        check("R8 irq cleared", {15'b0, irq}, 16'h0000);
        for (int k = 0; k < NW; k++) begin
            peek(3'd7, v); check("R3 status in drq", v, 16'h0048);
            bus_rd(3'd0, v); check("R3 word", v, id_exp(k));
        end
        peek(3'd7, v); check("R4 status after last", v, 16'h0040);
        bus_rd(3'd0, v); check("R4 data outside phase", v, 16'h0000);
        peek(3'd7, v); check("R4 status unchanged", v, 16'h0040);

        // R5 flush busy window
        bus_wr(3'd7, 8'hE7);
        for (int c = 0; c < NFL; c++) begin
            peek(3'd7, v); check("R5 busy window", v, 16'h00C0);
            check("R5 irq low while busy", {15'b0, irq}, 16'h0000);
            @(negedge clk);
        end
        peek(3'd7, v); check("R5 ready after window", v, 16'h0040);
        check("R5 irq at completion", {15'b0, irq}, 16'h0001);
        bus_rd(3'd7, v);

        // R6 every rejected opcode
        for (int op = 0; op < 256; op++) begin
            if (op == 'hEC || op == 'hE7) continue;
            bus_wr(3'd7, 8'(op));
            peek(3'd7, v); check("R6 status abort", v, 16'h0041);
            peek(3'd1, v); check("R6 error abort", v, 16'h0004);
            check("R6 irq", {15'b0, irq}, 16'h0001);
            bus_rd(3'd7, v);
            check("R8 irq cleared", {15'b0, irq}, 16'h0000);
        end

        // R7 accepted command clears error; R10 command during drq ignored
        bus_wr(3'd7, 8'hEC);
        peek(3'd7, v); check("R7 err cleared", v, 16'h0048);
        peek(3'd1, v); check("R7 error byte cleared", v, 16'h0000);
        bus_wr(3'd7, 8'hE7);
        peek(3'd7, v); check("R10 drq unaffected", v, 16'h0048);
        bus_wr(3'd7, 8'h00);
        peek(3'd1, v); check("R10 no abort in drq", v, 16'h0000);
        for (int k = 0; k < NW; k++) begin
            bus_rd(3'd0, v);
            if (k == 0 || k == NW - 1) check("R10 words continue", v, id_exp(k));
        end
        peek(3'd7, v); check("R10 drq done", v, 16'h0040);

        // R10 command during busy ignored
        bus_wr(3'd7, 8'hE7);
        bus_wr(3'd7, 8'h00);
        peek(3'd7, v); check("R10 busy unaffected", v, 16'h00C0);
        repeat (NFL) @(negedge clk);
        peek(3'd7, v); check("R10 flush ends clean", v, 16'h0040);
        peek(3'd1, v); check("R10 no abort in busy", v, 16'h0000);
        bus_rd(3'd7, v);

        // R9 deselected device
        bus_wr(3'd6, 8'h50);
        peek(3'd7, v); check("R9 status hidden", v, 16'h0000);
        peek(3'd1, v); check("R9 error hidden", v, 16'h0000);
        bus_wr(3'd7, 8'h00);
        bus_wr(3'd7, 8'hEC);
        check("R9 no irq", {15'b0, irq}, 16'h0000);
        bus_wr(3'd6, 8'h40);
        peek(3'd7, v); check("R9 command ignored", v, 16'h0040);
        peek(3'd1, v); check("R9 error untouched", v, 16'h0000);

        report();
    end
endmodule